// File: doc/BRIEF.md
# Indexed Colour Lookup Table with Palette Loader

This block holds a colour lookup table of 256 entries, each 12 bits of RGB. It fills the table from a stream of 16-bit palette words delivered over a valid/ready handshake. It then turns 8-bit pixel indices into 12-bit colours. The first word of every palette transfer doubles as a header. Its top nibble names the pixel format the palette was built for. The loader compares that code with the format configured on `cfg_fmt`, and only a match lets the transfer update the table.

How many words a transfer holds depends on the configured format. An 8-bpp palette fills all 256 entries. A direct-colour (16-bpp or 12-bpp) palette covers only entries 0 to 15. The 1-, 2- and 4-bpp formats take 128 entries. When the final word of a matching transfer is accepted, the block pulses `pal_loaded`. A mismatch raises `hdr_err` instead. The rest of that transfer is then drained without being written.

A pixel lookup and a palette load never run in the same cycle. While a lookup is requested, the loader withholds `pal_ready`.

Top module: `clut_palette_loader`

## Requirements
- R1: After reset, `rgb_valid`, `pal_loaded` and `hdr_err` are 0, and `pal_ready` is 1 while `pix_valid` is 0.
- R2: A palette word stores red from bits 11:8, green from bits 7:4 and blue from bits 3:0. A later lookup of that entry returns `rgb` = {red, green, blue}, which is bits 11:0 of the word.
- R3: `cfg_fmt` uses these codes: 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp indexed, 4 = 16/12 bpp direct. The header code in bits 15:12 of the first word must equal `cfg_fmt` for the transfer to count as a match.
- R4: The transfer length is 256 words for format 3, 16 words for format 4, and 128 words for formats 0 to 2. Word k writes entry k. `pal_loaded` is high for exactly one cycle, the cycle after the last word's handshake, and only on a match.
- R5: Entry 0 keeps only bits 11:0 of the header word, so the format code never reaches the colour of index 0.
- R6: On a mismatch, `hdr_err` rises in the cycle after the header handshake. The transfer's full length is still consumed. No entry is written and `pal_loaded` stays low. The next matching header clears `hdr_err`.
- R7: A lookup presented with `pix_valid` gives `rgb_valid` and `rgb` exactly one cycle later, one result per request.
- R8: While `pix_valid` is 1, `pal_ready` is 0 and no palette word is consumed.
- R9: A 16-word load leaves entries 16 to 255 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 3 | Configured pixel format code (0..4) |
| pal_valid | input | 1 | Palette word offered |
| pal_ready | output | 1 | Palette word accepted this cycle |
| pal_word | input | 16 | Palette word; header code in bits 15:12 of the first |
| pix_valid | input | 1 | Lookup request |
| pix_idx | input | 8 | Pixel index |
| rgb_valid | output | 1 | Lookup result valid |
| rgb | output | 12 | Looked-up colour {R,G,B} |
| pal_loaded | output | 1 | One-cycle pulse when a matching transfer completes |
| hdr_err | output | 1 | Header code did not match the configured format |

## Verification
The word counter and the in-transfer flag are the hidden state. If either goes wrong, the `pal_loaded` pulse lands in the wrong cycle, or the header of the next transfer is taken as a colour entry. The scoreboard then sees shifted colours in the very next lookups. A wrong match decision shows up in the cycle after the header, through `hdr_err`. It also shows up in lookups of entries that should have stayed untouched. Stall faults are caught by holding a header word against active lookups and checking that the pulse timing of the following load still fits the expected length.

// File: rtl/clut_palette_loader.sv
module clut_palette_loader #(
  parameter int IDX_W  = 8,
  parameter int COL_W  = 12,
  parameter int WORD_W = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_fmt,
  input  logic              pal_valid,
  output logic              pal_ready,
  input  logic [WORD_W-1:0] pal_word,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic              rgb_valid,
  output logic [COL_W-1:0]  rgb,
  output logic              pal_loaded,
  output logic              hdr_err
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST_FULL   = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] LAST_HALF   = IDX_W'(DEPTH / 2 - 1);
  localparam logic [IDX_W-1:0] LAST_DIRECT = IDX_W'(15);

  logic [COL_W-1:0] table_q [DEPTH];
  logic             loading, match_q;
  logic [IDX_W-1:0] wr_idx, last_idx, last_sel;
  logic             accept, hdr_match, we, at_end;
  logic [IDX_W-1:0] waddr;

  always_comb begin
    case (cfg_fmt)
      3'd3:    last_sel = LAST_FULL;
      3'd4:    last_sel = LAST_DIRECT;
      default: last_sel = LAST_HALF;
    endcase
  end

  assign pal_ready = ~pix_valid;
  assign accept    = pal_valid & pal_ready;
  assign hdr_match = pal_word[WORD_W-1 -: CODE_W] == CODE_W'(cfg_fmt);
  assign we        = accept & (loading ? match_q : hdr_match);
  assign waddr     = loading ? wr_idx : '0;
  assign at_end    = loading & (wr_idx == last_idx);

  always_ff @(posedge clk)
    if (we) table_q[waddr] <= pal_word[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loading    <= 1'b0;
      match_q    <= 1'b0;
      wr_idx     <= '0;
      last_idx   <= '0;
      pal_loaded <= 1'b0;
      hdr_err    <= 1'b0;
    end else begin
      pal_loaded <= 1'b0;
      if (accept) begin
        if (!loading) begin
          loading  <= 1'b1;
          match_q  <= hdr_match;
          hdr_err  <= ~hdr_match;
          wr_idx   <= IDX_W'(1);
          last_idx <= last_sel;
        end else begin
          wr_idx <= wr_idx + 1'b1;
          if (at_end) begin
            loading    <= 1'b0;
            pal_loaded <= match_q;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rgb_valid <= 1'b0;
    else        rgb_valid <= pix_valid;
  end

  always_ff @(posedge clk)
    if (pix_valid) rgb <= table_q[pix_idx];

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> rgb_valid);

  p_no_load_progress_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> ($stable(wr_idx) && $stable(loading)));

  p_loaded_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pal_loaded |=> !pal_loaded);

  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pal_loaded && hdr_err));

  p_err_on_hdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_err) |-> $past(accept && !loading));
endmodule

// File: tb/test_clut_palette_loader.sv
module test_clut_palette_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_fmt = 3'd3;
  logic        pal_valid = 1'b0;
  logic        pal_ready;
  logic [15:0] pal_word = '0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic        rgb_valid;
  logic [11:0] rgb;
  logic        pal_loaded, hdr_err;

  int checks = 0, failures = 0;
  logic [11:0] exp_tab [256];
  logic [11:0] sb [$];
  logic        prev_pv = 1'b0;

  always #10 clk = ~clk;

  clut_palette_loader i_clut_palette_loader (
    .clk, .rst_n, .cfg_fmt, .pal_valid, .pal_ready, .pal_word,
    .pix_valid, .pix_idx, .rgb_valid, .rgb, .pal_loaded, .hdr_err);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: R7 latency and R2 colour scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rgb_valid || prev_pv) check("R7 rgb_valid timing", rgb_valid, prev_pv);
      if (rgb_valid) begin
        if (sb.size() == 0) check("R7 unexpected result", 1, 0);
        else check("R2 lookup colour", rgb, sb.pop_front());
      end
    end
    prev_pv = pix_valid;
  end

  task automatic lookup(input int idx);
    pix_valid = 1'b1;
    pix_idx   = 8'(idx);
    sb.push_back(exp_tab[idx]);
    @(posedge clk); #1;
    pix_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [2:0] fmt, input logic [3:0] code, input int base);
    int n;
    logic m;
    logic [11:0] c;
    n = (fmt == 3) ? 256 : (fmt == 4) ? 16 : 128;
    m = (code == 4'(fmt));
    cfg_fmt = fmt;
    for (int i = 0; i < n; i++) begin
      c = 12'((base + i * 37) & 12'hfff);
      pal_word  = (i == 0) ? {code, c} : {4'(i + 5), c};
      pal_valid = 1'b1;
      @(negedge clk);
      while (!pal_ready) @(negedge clk);
      @(posedge clk); #1;
      if (m) exp_tab[i] = c;
    end
    pal_valid = 1'b0;
    @(negedge clk);
    check("R4 loaded pulse at end", pal_loaded, m);
    check("R6 header error flag", hdr_err, !m);
    @(posedge clk); #1;
    @(negedge clk);
    check("R4 loaded single cycle", pal_loaded, 0);
    @(posedge clk); #1;
  endtask

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 rgb_valid reset", rgb_valid, 0);
    check("R1 loaded reset", pal_loaded, 0);
    check("R1 err reset", hdr_err, 0);
    check("R1 ready idle", pal_ready, 1);
    @(posedge clk); #1;

    // R3/R4: full 8bpp palette
    load(3'd3, 4'h3, 5);
    lookup(0);   // R5: header nibble masked
    lookup(1); lookup(255); lookup(128);
    drain();
    for (int k = 0; k < 20; k++) lookup((k * 13) & 255); // R7 burst
    drain();

    // R4/R9: direct-colour palette of 16 entries
    load(3'd4, 4'h4, 9);
    lookup(15); lookup(16); lookup(200); lookup(0);
    drain();

    // R6: mismatching header
    load(3'd3, 4'h4, 333);
    lookup(0); lookup(3); lookup(255);
    drain();

    // R4/R6: 4bpp palette clears the error
    load(3'd2, 4'h2, 77);
    lookup(127); lookup(128); lookup(0);
    drain();

    // R8: header held while lookups run
    cfg_fmt   = 3'd1;
    pal_word  = {4'h1, 12'h0ab};
    pal_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      pix_valid = 1'b1;
      pix_idx   = 8'(k + 40);
      sb.push_back(exp_tab[k + 40]);
      @(negedge clk);
      check("R8 ready low during lookup", pal_ready, 0);
      @(posedge clk); #1;
    end
    pix_valid = 1'b0;
    load(3'd1, 4'h1, 500);
    lookup(0); lookup(127); lookup(64);
    drain();

    load(3'd0, 4'h0, 1234);
    lookup(1); lookup(200);
    drain();
    check("R7 scoreboard empty", sb.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule